// File: doc/BRIEF.md
# Bus-Master Disk DMA Control Registers

This block is the register file and control core of a bus-master disk DMA engine. Software reaches it through a small register port that takes byte accesses for the command and status registers and a full 32-bit access for the descriptor-table pointer. The block drives a run request, a transfer direction and the table base address to a separate transfer engine. The engine reports back end-of-table completion, errors and a pair of auxiliary pending flags, and the disk device's interrupt line also feeds in.

The status register holds three kinds of bit. Some are engine-owned and read-only: the transfer-in-progress bit and the two auxiliary flags. Two are event bits that stay set until software writes a one to them: error and device interrupt. Two are plain software-owned bits that mark whether drive unit 0 or unit 1 may use DMA. A supervising controller reads two decoded outputs. One is a completion verdict, which is good only when the low three status bits show "interrupt only". The other is a three-way classification of the status for use when a transfer times out.

Top module: `bmdma_regs`

## Requirements
- R1: A byte write to offset 0 sets the run bit (command bit 0) to wdata[0], and `eng_start` follows it one cycle later. A write of 1 while the run bit is 0 sets status bit 0 (active).
- R2: Command bit 3 is the direction bit, and `eng_to_mem` follows it (1 means device to memory). Only bits 0 and 3 of the command register are stored. All other bits read as 0, so a read-modify-write of the command byte keeps bits 0 and 3.
- R3: Status bit 0 (active) clears one cycle after an `eng_done` pulse, or after a command write with bit 0 = 0. It never reads 1 while `eng_start` is 0. `eng_done` leaves the run bit unchanged.
- R4: An `eng_err` pulse sets status bit 1. A 0-to-1 transition of `dev_irq` sets status bit 2. A `dev_irq` level that stays high does not set bit 2 again after software clears it.
- R5: A byte write to offset 2 clears status bit 1 when wdata[1] is 1 and clears bit 2 when wdata[2] is 1. If a set event for a bit arrives in the same cycle as its clear, the bit stays set.
- R6: A status write loads status bits 5 and 6 (DMA-capable flags for unit 0 and unit 1, bit 5 + unit) from wdata[6:5]. It leaves bits 0, 3 and 4 unchanged. Bit 7 always reads 0.
- R7: Status bits 4:3 show `eng_aux[1:0]` as registered one cycle earlier.
- R8: A dword write to offset 4 loads the table pointer with bits 1:0 forced to 0. A byte write to offset 4 has no effect on the pointer.
- R9: `cmp_good` is 1 exactly when status[2:0] = 3'b100. `cmp_status` always presents the full status byte.
- R10: `to_class` encodes 1 (keep waiting) when status bits 3 and 4 are both set. Otherwise it is 2 (fault) if bit 1 is set, 1 if bit 0 or bit 2 is set, and 0 (reset needed) if none of these holds.
- R11: Synchronous active-high reset clears command, status, pointer and the interrupt edge detector to 0.
- R12: Accepted accesses are byte at offsets 0 and 2 and dword at offset 4. Any other write is ignored. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_dword | input | 1 | 1 = dword access, 0 = byte access |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Write data (byte accesses use bits 7:0) |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| eng_done | input | 1 | End-of-table pulse from the transfer engine |
| eng_err | input | 1 | Error pulse from the transfer engine |
| dev_irq | input | 1 | Device interrupt level |
| eng_aux | input | 2 | Engine auxiliary pending flags |
| eng_start | output | 1 | Run request to the engine |
| eng_to_mem | output | 1 | Direction: 1 = device to memory |
| tbl_base | output | 32 | Descriptor table base address |
| cmp_good | output | 1 | Completion verdict: good |
| cmp_status | output | 8 | Status byte reported with the verdict |
| to_class | output | 2 | Timeout classification (0 reset, 1 wait, 2 fault) |

## Verification
A table of status combinations drives the completion and timeout decoders. Each combination is built through the real inputs: a start write for the active bit, an error pulse, an interrupt edge and the auxiliary flags. The table separates the single good pattern from its neighbours that also have active or error set. It also shows that both auxiliary flags override an error, that a single auxiliary flag does not, and that error outranks active. Directed cases then check that the clear-on-write bits are independent, that a set event wins over a clear in the same cycle, that a held interrupt level does not retrigger, that the command read-modify-write behaves as required, and that writes of the wrong width or to the wrong offset are dropped.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int REG_AW = 3;
    localparam int DATA_W = 32;

    localparam logic [REG_AW-1:0] OFS_CMD  = 3'd0;
    localparam logic [REG_AW-1:0] OFS_STAT = 3'd2;
    localparam logic [REG_AW-1:0] OFS_PTR  = 3'd4;

    localparam logic [7:0] CMD_MASK = 8'h09;

    typedef struct packed {
        logic       rsvd;
        logic [1:0] cap;
        logic [1:0] aux;
        logic       irq;
        logic       err;
        logic       act;
    } stat_t;

    typedef enum logic [1:0] {
        TO_RESET = 2'd0,
        TO_WAIT  = 2'd1,
        TO_FAULT = 2'd2
    } to_class_t;

    function automatic to_class_t classify(stat_t s);
        if (s.aux == 2'b11)      return TO_WAIT;
        if (s.err)               return TO_FAULT;
        if (s.act || s.irq)      return TO_WAIT;
        return TO_RESET;
    endfunction

    function automatic logic good_end(stat_t s);
        return {s.irq, s.err, s.act} == 3'b100;
    endfunction

endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] cmd_q,
    output logic       start_set,
    output logic       start_clr
);
    always_comb begin
        start_set = wr_en &  wdata[0] & ~cmd_q[0];
        start_clr = wr_en & ~wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst)        cmd_q <= '0;
        else if (wr_en) cmd_q <= wdata & CMD_MASK;
    end
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       start_set,
    input  logic       start_clr,
    input  logic       eng_done,
    input  logic       eng_err,
    input  logic       dev_irq,
    input  logic [1:0] eng_aux,
    output stat_t      stat_q
);
    logic  irq_q;
    logic  irq_rise;
    stat_t stat_n;

    always_comb begin
        irq_rise = dev_irq & ~irq_q;
        stat_n   = stat_q;
        stat_n.aux  = eng_aux;
        stat_n.rsvd = 1'b0;
        // software side first, hardware events afterwards so they win
        if (wr_en) begin
            if (wdata[1]) stat_n.err = 1'b0;
            if (wdata[2]) stat_n.irq = 1'b0;
            stat_n.cap = wdata[6:5];
        end
        if (eng_err)   stat_n.err = 1'b1;
        if (irq_rise)  stat_n.irq = 1'b1;
        if (eng_done)  stat_n.act = 1'b0;
        if (start_clr) stat_n.act = 1'b0;
        if (start_set) stat_n.act = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_n;
            irq_q  <= dev_irq;
        end
    end
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
    parameter int PTR_W     = 32,
    parameter int ALIGN_LSB = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wdata,
    output logic [PTR_W-1:0] ptr
);
    localparam int HI_W = PTR_W - ALIGN_LSB;

    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst)        hi_q <= '0;
        else if (wr_en) hi_q <= wdata[PTR_W-1:ALIGN_LSB];
    end

    generate
        if (ALIGN_LSB == 0) begin : g_unaligned
            assign ptr = hi_q;
        end else begin : g_aligned
            assign ptr = {hi_q, {ALIGN_LSB{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/bmdma_judge.sv
module bmdma_judge
    import bmdma_pkg::*;
(
    input  stat_t      stat,
    output logic       good,
    output to_class_t  tclass
);
    always_comb begin
        good   = good_end(stat);
        tclass = classify(stat);
    end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int PTR_W     = DATA_W,
    parameter int ALIGN_LSB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_dword,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              dev_irq,
    input  logic [1:0]        eng_aux,
    output logic              eng_start,
    output logic              eng_to_mem,
    output logic [PTR_W-1:0]  tbl_base,
    output logic              cmp_good,
    output logic [7:0]        cmp_status,
    output logic [1:0]        to_class
);
    logic      wr_cmd, wr_stat, wr_ptr;
    logic [7:0] cmd_q;
    logic      start_set, start_clr;
    stat_t     stat_q;
    to_class_t tclass;

    always_comb begin
        wr_cmd  = reg_wr & ~reg_dword & (reg_addr == OFS_CMD);
        wr_stat = reg_wr & ~reg_dword & (reg_addr == OFS_STAT);
        wr_ptr  = reg_wr &  reg_dword & (reg_addr == OFS_PTR);
    end

    bmdma_cmd_reg u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_cmd),
        .wdata     (reg_wdata[7:0]),
        .cmd_q     (cmd_q),
        .start_set (start_set),
        .start_clr (start_clr)
    );

    bmdma_stat_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_stat),
        .wdata     (reg_wdata[7:0]),
        .start_set (start_set),
        .start_clr (start_clr),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .dev_irq   (dev_irq),
        .eng_aux   (eng_aux),
        .stat_q    (stat_q)
    );

    bmdma_ptr_reg #(.PTR_W(PTR_W), .ALIGN_LSB(ALIGN_LSB)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_ptr),
        .wdata (reg_wdata[PTR_W-1:0]),
        .ptr   (tbl_base)
    );

    bmdma_judge u_judge (
        .stat   (stat_q),
        .good   (cmp_good),
        .tclass (tclass)
    );

    always_comb begin
        eng_start  = cmd_q[0];
        eng_to_mem = cmd_q[3];
        cmp_status = stat_q;
        to_class   = tclass;
        unique case (reg_addr)
            OFS_CMD:  reg_rdata = {{(DATA_W-8){1'b0}}, cmd_q};
            OFS_STAT: reg_rdata = {{(DATA_W-8){1'b0}}, stat_q};
            OFS_PTR:  reg_rdata = DATA_W'(tbl_base);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
    parameter int PTR_W     = 32,
    parameter int ALIGN_LSB = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_dword,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             eng_done,
    input logic             eng_err,
    input logic             dev_irq,
    input logic [1:0]       eng_aux,
    input logic             eng_start,
    input logic             eng_to_mem,
    input logic [PTR_W-1:0] tbl_base,
    input logic [7:0]       cmp_status
);
    logic c_cmd, c_stat, c_ptr;
    assign c_cmd  = reg_wr && !reg_dword && reg_addr == 3'd0;
    assign c_stat = reg_wr && !reg_dword && reg_addr == 3'd2;
    assign c_ptr  = reg_wr &&  reg_dword && reg_addr == 3'd4;

    p_start_r1: assert property (@(posedge clk) disable iff (rst)
        c_cmd |=> eng_start == $past(reg_wdata[0]));

    p_dir_r2: assert property (@(posedge clk) disable iff (rst)
        c_cmd |=> eng_to_mem == $past(reg_wdata[3]));

    p_act_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
        cmp_status[0] |-> eng_start);

    p_done_r3: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !c_cmd) |=> !cmp_status[0]);

    p_err_set_r4: assert property (@(posedge clk) disable iff (rst)
        eng_err |=> cmp_status[1]);

    p_irq_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (dev_irq && !$past(dev_irq)) |=> cmp_status[2]);

    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (c_stat && reg_wdata[2:1] == 2'b11 && !eng_err && !(dev_irq && !$past(dev_irq)))
        |=> cmp_status[2:1] == 2'b00);

    p_cap_r6: assert property (@(posedge clk) disable iff (rst)
        c_stat |=> cmp_status[6:5] == $past(reg_wdata[6:5]));

    p_keep_act_r6: assert property (@(posedge clk) disable iff (rst)
        (c_stat && !eng_done) |=> cmp_status[0] == $past(cmp_status[0]));

    p_aux_r7: assert property (@(posedge clk) disable iff (rst)
        eng_wr_any_cycle |=> cmp_status[4:3] == $past(eng_aux));

    p_ptr_r8: assert property (@(posedge clk) disable iff (rst)
        c_ptr |=> tbl_base[PTR_W-1:ALIGN_LSB] == $past(reg_wdata[PTR_W-1:ALIGN_LSB]));

    p_reset_r11: assert property (@(posedge clk)
        rst |=> (cmp_status == 8'h00 && !eng_start && !eng_to_mem && tbl_base == '0));

    logic eng_wr_any_cycle;
    assign eng_wr_any_cycle = !rst;
endmodule

bind bmdma_regs bmdma_regs_chk #(.PTR_W(PTR_W), .ALIGN_LSB(ALIGN_LSB)) u_chk (.*);

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
    import bmdma_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_dword = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic        dev_irq = 1'b0;
    logic [1:0]  eng_aux = '0;
    logic        eng_start, eng_to_mem, cmp_good;
    logic [31:0] tbl_base;
    logic [7:0]  cmp_status;
    logic [1:0]  to_class;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    bmdma_regs uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_dword(reg_dword),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_done(eng_done), .eng_err(eng_err), .dev_irq(dev_irq),
        .eng_aux(eng_aux), .eng_start(eng_start), .eng_to_mem(eng_to_mem),
        .tbl_base(tbl_base), .cmp_good(cmp_good), .cmp_status(cmp_status),
        .to_class(to_class)
    );

    // vector: [7:6] aux, [5] start, [4] err, [3] irq edge, [2] good, [1:0] class
    localparam int NV = 11;
    localparam logic [7:0] VEC [NV] = '{
        8'b00_0_0_1_1_01,
        8'b00_0_0_0_0_00,
        8'b00_1_0_0_0_01,
        8'b00_0_1_0_0_10,
        8'b00_0_1_1_0_10,
        8'b00_1_0_1_0_01,
        8'b11_0_1_0_0_01,
        8'b11_0_0_0_0_01,
        8'b01_0_1_0_0_10,
        8'b10_0_0_0_0_00,
        8'b00_1_1_1_0_10
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic dw, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_dword = dw; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_dword = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_err();
        @(negedge clk); eng_err = 1'b1;
        @(negedge clk); eng_err = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R11 reset state
        rd(3'd0, d); chk("R11 cmd after reset", d, 0);
        rd(3'd2, d); chk("R11 status after reset", d, 0);
        rd(3'd4, d); chk("R11 pointer after reset", d, 0);
        chk("R11 outputs after reset", {eng_start, eng_to_mem, to_class}, 0);

        // R9 R10 table walk
        for (int i = 0; i < NV; i++) begin
            logic [7:0] v;
            v = VEC[i];
            @(negedge clk); dev_irq = 1'b0; eng_aux = 2'b00;
            wr(1'b0, 3'd0, 32'h0);
            wr(1'b0, 3'd2, 32'h06);
            @(negedge clk); eng_aux = v[7:6];
            if (v[5]) wr(1'b0, 3'd0, 32'h01);
            if (v[4]) pulse_err();
            if (v[3]) begin @(negedge clk); dev_irq = 1'b1; end
            @(negedge clk);
            chk($sformatf("R9 vec%0d good", i), cmp_good, v[2]);
            chk($sformatf("R9 vec%0d status", i), cmp_status,
                {3'b000, v[7:6], v[3], v[4], v[5]});
            chk($sformatf("R10 vec%0d class", i), to_class, v[1:0]);
        end
        @(negedge clk); dev_irq = 1'b0; eng_aux = 2'b00;
        wr(1'b0, 3'd2, 32'h06);
        wr(1'b0, 3'd0, 32'h0);

        // R1 R3 start and done
        wr(1'b0, 3'd0, 32'h01);
        chk("R1 run output", eng_start, 1);
        rd(3'd2, d); chk("R1 active set", d[0], 1);
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        rd(3'd2, d); chk("R3 done clears active", d[0], 0);
        chk("R3 done keeps run bit", eng_start, 1);
        wr(1'b0, 3'd0, 32'h01);
        rd(3'd2, d); chk("R1 rewrite while running no restart", d[0], 0);
        wr(1'b0, 3'd0, 32'h00);
        wr(1'b0, 3'd0, 32'h01);
        rd(3'd2, d); chk("R1 restart after stop", d[0], 1);
        wr(1'b0, 3'd0, 32'h00);
        rd(3'd2, d); chk("R3 stop clears active", d[0], 0);

        // R2 direction and masking
        wr(1'b0, 3'd0, 32'hFF);
        rd(3'd0, d); chk("R2 only bits 0 and 3 stored", d, 32'h09);
        chk("R2 direction out", eng_to_mem, 1);
        wr(1'b0, 3'd0, d & ~32'h1);
        rd(3'd0, d); chk("R2 rmw keeps direction", d, 32'h08);
        chk("R2 run stopped by rmw", {eng_start, eng_to_mem}, 2'b01);
        wr(1'b0, 3'd0, 32'h0);

        // R4 level irq does not retrigger
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk);
        rd(3'd2, d); chk("R4 irq edge sets", d[2], 1);
        wr(1'b0, 3'd2, 32'h04);
        @(negedge clk);
        rd(3'd2, d); chk("R4 held level no retrigger", d[2], 0);
        @(negedge clk); dev_irq = 1'b0;

        // R5 independent clears and set priority
        pulse_err();
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk);
        wr(1'b0, 3'd2, 32'h02);
        rd(3'd2, d); chk("R5 clear err keeps irq", d[2:1], 2'b10);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h02; eng_err = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; eng_err = 1'b0;
        rd(3'd2, d); chk("R5 set wins over clear", d[1], 1);
        wr(1'b0, 3'd2, 32'h06);
        @(negedge clk); dev_irq = 1'b0;

        // R6 R7 capability bits and aux untouched by status write
        @(negedge clk); eng_aux = 2'b10;
        wr(1'b0, 3'd0, 32'h01);
        wr(1'b0, 3'd2, 32'h20);
        rd(3'd2, d); chk("R6 unit0 flag with active and aux kept", d, 32'h31);
        wr(1'b0, 3'd2, 32'hD9);
        rd(3'd2, d); chk("R6 unit1 flag only, bit7 zero", d, 32'h51);
        chk("R7 aux mirror", cmp_status[4:3], 2'b10);
        wr(1'b0, 3'd0, 32'h0);
        @(negedge clk); eng_aux = 2'b00;

        // R8 R12 pointer and access width
        wr(1'b1, 3'd4, 32'h12345677);
        chk("R8 pointer aligned", tbl_base, 32'h12345674);
        wr(1'b0, 3'd4, 32'h000000AA);
        rd(3'd4, d); chk("R8 byte write to pointer ignored", d, 32'h12345674);
        wr(1'b1, 3'd0, 32'h00000009);
        rd(3'd0, d); chk("R12 dword write to cmd ignored", d, 0);
        rd(3'd6, d); chk("R12 unmapped read zero", d, 0);

        // R11 reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R11 reset clears pointer", tbl_base, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule